// File: doc/BRIEF.md
# Memory Request Issue Throttle

This block sits between an in-order queue of executed vector memory operations and the downstream translation and memory port. Each cycle it looks at the head entry, sorts its operation code into a load-side or store-side class, and compares the matching in-flight count against a configured depth. When there is room and the downstream side is ready, it launches the head and pops the queue. Otherwise the head stays where it is.

Two credit counters track outstanding work. Every load-side launch takes a load credit. On the store side, only a plain store takes a credit, although every store-side operation must pass the store check. Completion pulses from the return path give credits back. A counter never goes below zero. A launch and a completion on the same counter in one cycle leave it unchanged.

Top module: `mem_issue_throttle`

## Requirements
- R1: Op codes 0 (load), 2 (atomic with return) and 3 (atomic without return) are load-side. A load-side head is offered (`mem_valid_o`=1) only while the load count is below `DEPTH`.
- R2: Every other op code (1, 4, 5, 6, 7) is store-side. A store-side head is offered only while the store count is below `DEPTH`.
- R3: While the count for the head's class is at `DEPTH` or above, `mem_valid_o` and `head_pop_o` stay 0, and the head is held.
- R4: A load-side launch increments the load count by one in the following cycle.
- R5: Only op code 1 (plain store) increments the store count on launch. Codes 4 to 7 launch without changing either count.
- R6: A launch happens when `head_valid_i`, room and `mem_ready_i` are all high. `head_pop_o` equals that launch, so at most one entry is popped per cycle.
- R7: A pulse on `ld_done_i` or `st_done_i` decrements the matching count. A pulse on a count that is already zero leaves it at zero.
- R8: When a launch and a completion hit the same counter in one cycle, that count is unchanged.
- R9: After reset, both counts are zero.
- R10: `mem_op_o` and `mem_tag_o` carry `head_op_i` and `head_tag_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| head_valid_i | input | 1 | Queue head holds an entry |
| head_op_i | input | 3 | Head operation code |
| head_tag_i | input | TAG_W | Head request tag |
| head_pop_o | output | 1 | Pop the head; the entry was launched |
| mem_valid_o | output | 1 | Request offered downstream |
| mem_ready_i | input | 1 | Downstream accepts the request |
| mem_op_o | output | 3 | Operation code sent downstream |
| mem_tag_o | output | TAG_W | Tag sent downstream |
| ld_done_i | input | 1 | A load-side request completed |
| st_done_i | input | 1 | A store-side request completed |
| ld_cnt_o | output | CNT_W | Load-side requests in flight |
| st_cnt_o | output | CNT_W | Plain stores in flight |

## Verification
The bench builds the block with `DEPTH`=2 and `TAG_W`=4. At this depth, two launches fill a counter. This makes it quick to reach the full-counter stall, a store-side operation that launches without a credit while the store count sits below the limit, and the same-cycle launch and completion at a non-zero count. The small depth also lets the bench drain both counters to zero and then pulse completions again, which exercises the floor at zero.

// File: rtl/mit_pkg.sv
package mit_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_ATOM_RET = 3'd2,
    OP_ATOM_NR  = 3'd3,
    OP_FENCE    = 3'd4,
    OP_MISC5    = 3'd5,
    OP_MISC6    = 3'd6,
    OP_MISC7    = 3'd7
  } mem_op_e;

  localparam int SIDE_LD = 0;
  localparam int SIDE_ST = 1;
  localparam int N_SIDE  = 2;
endpackage

// File: rtl/mit_op_class.sv
module mit_op_class
  import mit_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            load_side_o,
  output logic            takes_st_credit_o
);
  always_comb begin
    load_side_o       = 1'b0;
    takes_st_credit_o = 1'b0;
    unique case (mem_op_e'(op_i))
      OP_LOAD, OP_ATOM_RET, OP_ATOM_NR: load_side_o = 1'b1;
      OP_STORE:                         takes_st_credit_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mit_credit_ctr.sv
module mit_credit_ctr #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          room_o
);
  logic dec_ok;
  assign dec_ok = dec_i && (cnt_o != '0);   // floor at zero
  assign room_o = cnt_o < CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (inc_i && !dec_ok) cnt_o <= cnt_o + 1'b1;
    else if (dec_ok && !inc_i) cnt_o <= cnt_o - 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
  assert_inc_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> room_o);
  assert_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !inc_i) |=> cnt_o == '0);
  assert_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i && cnt_o != '0) |=> cnt_o == $past(cnt_o));
endmodule

// File: rtl/mem_issue_throttle.sv
module mem_issue_throttle
  import mit_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_valid_i,
  input  logic [OP_W-1:0]  head_op_i,
  input  logic [TAG_W-1:0] head_tag_i,
  output logic             head_pop_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [OP_W-1:0]  mem_op_o,
  output logic [TAG_W-1:0] mem_tag_o,
  input  logic             ld_done_i,
  input  logic             st_done_i,
  output logic [CNT_W-1:0] ld_cnt_o,
  output logic [CNT_W-1:0] st_cnt_o
);
  logic             load_side, st_credit, room_sel, launch;
  logic [N_SIDE-1:0] inc, dec, room;
  logic [CNT_W-1:0]  cnt [N_SIDE];

  mit_op_class u_class (
    .op_i              (head_op_i),
    .load_side_o       (load_side),
    .takes_st_credit_o (st_credit)
  );

  assign room_sel    = load_side ? room[SIDE_LD] : room[SIDE_ST];
  assign mem_valid_o = head_valid_i && room_sel;
  assign launch      = mem_valid_o && mem_ready_i;
  assign head_pop_o  = launch;
  assign mem_op_o    = head_op_i;
  assign mem_tag_o   = head_tag_i;

  assign inc[SIDE_LD] = launch && load_side;
  assign inc[SIDE_ST] = launch && st_credit;
  assign dec[SIDE_LD] = ld_done_i;
  assign dec[SIDE_ST] = st_done_i;

  for (genvar g = 0; g < N_SIDE; g++) begin : g_ctr
    mit_credit_ctr #(.DEPTH(DEPTH), .CW(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .dec_i  (dec[g]),
      .cnt_o  (cnt[g]),
      .room_o (room[g])
    );
  end

  assign ld_cnt_o = cnt[SIDE_LD];
  assign st_cnt_o = cnt[SIDE_ST];

  assert_pop_handshake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_pop_o |-> (head_valid_i && mem_ready_i));
  assert_ld_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_side && ld_cnt_o >= CNT_W'(DEPTH)) |-> !mem_valid_o && !head_pop_o);
  assert_st_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_side && st_cnt_o >= CNT_W'(DEPTH)) |-> !mem_valid_o && !head_pop_o);
  assert_ld_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_pop_o && load_side && !ld_done_i) |=> ld_cnt_o == $past(ld_cnt_o) + 1'b1);
  assert_st_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_pop_o && !load_side && !st_credit && !st_done_i) |=> $stable(st_cnt_o));
endmodule

// File: tb/sim_mem_issue_throttle.sv
module sim_mem_issue_throttle;
  localparam int DEPTH = 2;
  localparam int TAG_W = 4;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 16;

  logic clk = 0, rst_n = 0;
  logic hv = 0, rdy = 0, ldd = 0, std = 0;
  logic [2:0] op = '0;
  logic [TAG_W-1:0] tag = '0;
  logic pop, mv;
  logic [2:0] mop;
  logic [TAG_W-1:0] mtag;
  logic [CW-1:0] ldc, stc;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  mem_issue_throttle #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .head_valid_i(hv), .head_op_i(op), .head_tag_i(tag),
    .head_pop_o(pop), .mem_valid_o(mv), .mem_ready_i(rdy), .mem_op_o(mop), .mem_tag_o(mtag),
    .ld_done_i(ldd), .st_done_i(std), .ld_cnt_o(ldc), .st_cnt_o(stc));

  // {v, op[2:0], rdy, ldd, std, exp_valid, exp_pop, exp_ld[1:0], exp_st[1:0], 3'b0}
  function automatic logic [15:0] mk(bit v, int o, bit r, bit l, bit s,
                                     bit ev, bit ep, int el, int es);
    return {v, 3'(o), r, l, s, ev, ep, 2'(el), 2'(es), 3'b000};
  endfunction

  localparam logic [15:0] VEC [NV] = '{
    mk(1,0,1,0,0, 1,1, 1,0),
    mk(1,2,1,0,0, 1,1, 2,0),
    mk(1,3,1,0,0, 0,0, 2,0),
    mk(1,1,1,0,0, 1,1, 2,1),
    mk(1,4,1,0,0, 1,1, 2,1),
    mk(1,1,0,0,0, 1,0, 2,1),
    mk(1,1,1,0,0, 1,1, 2,2),
    mk(1,5,1,0,0, 0,0, 2,2),
    mk(1,3,1,1,0, 0,0, 1,2),
    mk(1,3,1,1,0, 1,1, 1,2),
    mk(0,0,1,0,1, 0,0, 1,1),
    mk(1,1,1,0,1, 1,1, 1,1),
    mk(0,0,1,1,1, 0,0, 0,0),
    mk(0,0,1,1,1, 0,0, 0,0),
    mk(1,7,1,0,0, 1,1, 0,0),
    mk(1,6,1,0,0, 1,1, 0,0)
  };

  string TAGS [NV] = '{"R4","R1","R1","R5","R5","R6","R5","R2",
                       "R3","R8","R7","R8","R7","R7","R5","R5"};

  task automatic chk(string r, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 10000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 10000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", int'(ldc), 0, "load count in reset");
    chk("R9", int'(stc), 0, "store count in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R9", int'(ldc), 0, "load count after reset");
    chk("R6", int'(pop), 0, "pop with empty queue");

    for (int i = 0; i < NV; i++) begin
      logic [15:0] e;
      e = VEC[i];
      @(negedge clk);
      hv = e[15]; op = e[14:12]; rdy = e[11]; ldd = e[10]; std = e[9];
      tag = TAG_W'(i);
      #1;
      chk(TAGS[i], int'(mv),  int'(e[8]), $sformatf("vec %0d mem_valid", i));
      chk(TAGS[i], int'(pop), int'(e[7]), $sformatf("vec %0d pop", i));
      chk("R10", int'(mtag), i % 16, $sformatf("vec %0d tag", i));
      chk("R10", int'(mop), int'(e[14:12]), $sformatf("vec %0d op", i));
      @(posedge clk); #1;
      hv = 0; ldd = 0; std = 0;
      chk(TAGS[i], int'(ldc), int'(e[6:5]), $sformatf("vec %0d load count", i));
      chk(TAGS[i], int'(stc), int'(e[4:3]), $sformatf("vec %0d store count", i));
    end

    // R3: head held across several cycles while loads are full
    @(negedge clk); hv = 1; op = 3'd0; rdy = 1;
    @(negedge clk); @(negedge clk); hv = 1; op = 3'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R3", int'(pop), 0, "held load head pop");
      chk("R3", int'(ldc), DEPTH, "held load count");
    end
    // store-side head still launches while loads are full
    op = 3'd1; #1;
    chk("R2", int'(pop), 1, "store launches while loads full");
    @(negedge clk); hv = 0;

    // reset mid-run clears counts
    rst_n = 0; #1;
    chk("R9", int'(ldc), 0, "load count after async reset");
    chk("R9", int'(stc), 0, "store count after async reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule